// File: doc/BRIEF.md
# Two-Level Translation Lookaside Buffer

This block caches virtual-to-physical page translations at two levels. An instruction-side micro TLB and a data-side micro TLB each answer their own requester in the same cycle. A micro miss falls through to one shared main TLB. If the main TLB hits, its entry is copied into the micro TLB that missed. If it misses, the block raises a table-walk request and waits for a refill entry. That refill is written into both the main TLB and the micro TLB that asked for it.

Every entry holds:
- a virtual page tag and a physical page base;
- a page size of 4KB, 64KB, 1MB or 16MB;
- an address space identifier (ASID) and a global flag;
- a domain number and attribute bits.

Tagging by ASID means a context switch needs no flush. A few main TLB slots can be pinned, so replacement never evicts them. Two maintenance inputs clear entries: one clears everything, the other clears one ASID.

Top module: `two_level_tlb`

## Requirements
- R1: A micro TLB hit shows `x_hit` high in the same cycle as the request. The physical address is the entry's page base above the page offset and the request's offset bits below it.
- R2: Page size codes are 0=4KB, 1=64KB, 2=1MB and 3=16MB. These give 12, 16, 20 and 24 offset bits. Any address inside a cached page hits, and an address outside it does not.
- R3: An entry matches only when its global flag is set or its stored ASID equals `cur_asid`. A non-global entry cached under one ASID misses under another and hits again when that ASID returns.
- R4: Suppose a micro TLB misses and the main TLB hits. The entry is copied into that micro TLB at the next edge, so the hit appears one cycle after the request, and no walk is raised.
- R5: Suppose both micro TLBs miss in the same cycle and both pages are in the main TLB. The data side hits one cycle after the request and the instruction side two cycles after.
- R6: A main TLB miss raises `walk_req` with `walk_va` and `walk_side` (1 = data, 0 = instruction) one cycle after the request. These hold until a cycle with `walk_valid`. The refill is written to the main TLB and the requesting micro TLB, and the hit appears the cycle after `walk_valid`.
- R7: Each 8-entry micro TLB replaces in round-robin order. After nine distinct refills the first page is gone from the micro TLB but is still served by the main TLB one cycle after the request.
- R8: The main TLB has 32 entries. Slots 0 to 3 are lockable and the other 28 are replaced round-robin. A refill with `lock_en` high goes into slot `lock_idx`, and round-robin refills never evict it.
- R9: `inv_all` clears both micro TLBs and every unlocked main TLB entry in one cycle. Locked main TLB entries survive it.
- R10: `inv_asid_en` removes, in one cycle and from both levels, every non-global entry whose ASID equals `inv_asid`. Global entries and entries of other ASIDs stay.
- R11: `x_domain` and `x_attr` report the domain number (0 to 15) and attribute bits of the hitting entry.
- R12: After reset no entry is valid, both hit outputs are low and `walk_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cur_asid | input | 8 | ASID of the running context |
| i_req | input | 1 | Instruction-side lookup request |
| i_va | input | 32 | Instruction-side virtual address |
| i_hit | output | 1 | Instruction-side translation valid |
| i_pa | output | 32 | Instruction-side physical address |
| i_domain | output | 4 | Domain of the instruction-side entry |
| i_attr | output | 4 | Attributes of the instruction-side entry |
| d_req | input | 1 | Data-side lookup request |
| d_va | input | 32 | Data-side virtual address |
| d_hit | output | 1 | Data-side translation valid |
| d_pa | output | 32 | Data-side physical address |
| d_domain | output | 4 | Domain of the data-side entry |
| d_attr | output | 4 | Attributes of the data-side entry |
| walk_req | output | 1 | Table walk needed |
| walk_side | output | 1 | Walk requester, 1 = data |
| walk_va | output | 32 | Address to walk |
| walk_valid | input | 1 | Refill entry present |
| walk_pbase | input | 20 | Refill physical page number |
| walk_size | input | 2 | Refill page size code |
| walk_global | input | 1 | Refill global flag |
| walk_domain | input | 4 | Refill domain number |
| walk_attr | input | 4 | Refill attribute bits |
| lock_en | input | 1 | Put this refill in a locked slot |
| lock_idx | input | 2 | Locked slot to use |
| inv_all | input | 1 | Invalidate all unlocked entries |
| inv_asid_en | input | 1 | Invalidate by ASID |
| inv_asid | input | 8 | ASID to invalidate |

## Verification
The properties rely on the following conduct from the environment:
- A requester keeps its address and `cur_asid` steady until its hit appears.
- `walk_valid` and `lock_en` are only driven while `walk_req` is high.
- A refill never duplicates a page already present at the same level.

The bench tasks meet these conditions. Each request is raised on one side at a time, except in the deliberate two-sided case. Addresses are held until the hit arrives, and the walk response is answered for exactly one cycle. Every walked page is distinct from what is cached, and maintenance pulses are issued only while no walk is pending.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int VA_W   = 32;
   localparam int OFF_W  = 12;
   localparam int PG_W   = VA_W - OFF_W;
   localparam int ASID_W = 8;
   localparam int DOM_W  = 4;
   localparam int ATTR_W = 4;

   typedef enum logic [1:0] {PG_4K = 2'd0, PG_64K = 2'd1, PG_1M = 2'd2, PG_16M = 2'd3} pg_size_e;

   typedef struct packed {
      logic [PG_W-1:0]   vtag;
      logic [PG_W-1:0]   pbase;
      pg_size_e          size;
      logic [ASID_W-1:0] asid;
      logic              glob;
      logic [DOM_W-1:0]  dom;
      logic [ATTR_W-1:0] attr;
   } tlb_ent_t;

   // page-number bits that take part in the compare for a given size
   function automatic logic [PG_W-1:0] pg_mask(pg_size_e s);
      case (s)
         PG_64K:  pg_mask = ~PG_W'(20'h0000F);
         PG_1M:   pg_mask = ~PG_W'(20'h000FF);
         PG_16M:  pg_mask = ~PG_W'(20'h00FFF);
         default: pg_mask = '1;
      endcase
   endfunction

   function automatic logic ent_match(tlb_ent_t e, logic [VA_W-1:0] va, logic [ASID_W-1:0] asid);
      logic [PG_W-1:0] m;
      m = pg_mask(e.size);
      ent_match = (((va[VA_W-1:OFF_W] ^ e.vtag) & m) == '0) && (e.glob || (e.asid == asid));
   endfunction

   function automatic logic [VA_W-1:0] xlate(tlb_ent_t e, logic [VA_W-1:0] va);
      logic [PG_W-1:0] m;
      m = pg_mask(e.size);
      xlate = {(e.pbase & m) | (va[VA_W-1:OFF_W] & ~m), va[OFF_W-1:0]};
   endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
   import tlb_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int NLOCK = 0,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output tlb_ent_t          lk_ent,
   input  logic              wr_en,
   input  tlb_ent_t          wr_ent,
   input  logic              wr_lock,
   input  logic [LW-1:0]     wr_lock_idx,
   input  logic              inv_all,
   input  logic              inv_asid_en,
   input  logic [ASID_W-1:0] inv_asid
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("tlb_cam: DEPTH must be at least 2");
   end
   if (NLOCK >= DEPTH) begin : g_bad_lock
      $error("tlb_cam: NLOCK must be below DEPTH");
   end

   tlb_ent_t         ent_q [DEPTH];
   logic [DEPTH-1:0] vld_q, vld_d, hit_vec;
   logic [IW-1:0]    rr_q, widx;
   logic             lock_wr;

   // lookup
   always_comb begin
      hit_vec = '0;
      lk_hit  = 1'b0;
      lk_ent  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         hit_vec[i] = vld_q[i] && ent_match(ent_q[i], lk_va, lk_asid);
         if (hit_vec[i]) begin
            lk_hit = 1'b1;
            lk_ent = ent_q[i];
         end
      end
   end

   // victim choice: locked slot on request, else round-robin over unlocked range
   if (NLOCK > 0) begin : g_lock
      assign lock_wr = wr_en && wr_lock;
      assign widx    = wr_lock ? IW'(wr_lock_idx) : rr_q;
   end else begin : g_nolock
      logic unused_lock;
      assign unused_lock = ^{wr_lock, wr_lock_idx};
      assign lock_wr     = 1'b0;
      assign widx        = rr_q;
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         vld_d[i] = vld_q[i]
                    && !(inv_all && (i >= NLOCK))
                    && !(inv_asid_en && !ent_q[i].glob && (ent_q[i].asid == inv_asid));
         if (wr_en && (widx == IW'(i))) vld_d[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         rr_q  <= IW'(NLOCK);
      end else begin
         vld_q <= vld_d;
         if (wr_en && !lock_wr)
            rr_q <= (rr_q == IW'(DEPTH-1)) ? IW'(NLOCK) : rr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) ent_q[widx] <= wr_ent;
   end

   // checker state: which ASID was last invalidated
   logic [ASID_W-1:0] inv_asid_q;
   logic              asid_left;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inv_asid_q <= '0;
      else        inv_asid_q <= inv_asid;
   end
   always_comb begin
      asid_left = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (vld_q[i] && !ent_q[i].glob && (ent_q[i].asid == inv_asid_q)) asid_left = 1'b1;
   end

   AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec)); // R1
   AST_RR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (rr_q >= IW'(NLOCK)) && (rr_q <= IW'(DEPTH-1))); // R8
   AST_INVALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (inv_all && !wr_en) |=> ((vld_q >> NLOCK) == '0)); // R9
   AST_ASID_GONE: assert property (@(posedge clk) disable iff (!rst_n) (inv_asid_en && !wr_en) |=> !asid_left); // R10

   if (NLOCK > 0) begin : g_lock_chk
      AST_LOCK_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
         (inv_all && !inv_asid_en && !wr_en) |=> (vld_q[NLOCK-1:0] == $past(vld_q[NLOCK-1:0]))); // R9
   end
endmodule

// File: rtl/two_level_tlb.sv
module two_level_tlb
   import tlb_pkg::*;
#(
   parameter int MICRO_DEPTH = 8,
   parameter int MAIN_DEPTH  = 32,
   parameter int MAIN_LOCK   = 4,
   localparam int LOCK_W = (MAIN_LOCK > 1) ? $clog2(MAIN_LOCK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              i_req,
   input  logic [VA_W-1:0]   i_va,
   output logic              i_hit,
   output logic [VA_W-1:0]   i_pa,
   output logic [DOM_W-1:0]  i_domain,
   output logic [ATTR_W-1:0] i_attr,
   input  logic              d_req,
   input  logic [VA_W-1:0]   d_va,
   output logic              d_hit,
   output logic [VA_W-1:0]   d_pa,
   output logic [DOM_W-1:0]  d_domain,
   output logic [ATTR_W-1:0] d_attr,
   output logic              walk_req,
   output logic              walk_side,
   output logic [VA_W-1:0]   walk_va,
   input  logic              walk_valid,
   input  logic [PG_W-1:0]   walk_pbase,
   input  logic [1:0]        walk_size,
   input  logic              walk_global,
   input  logic [DOM_W-1:0]  walk_domain,
   input  logic [ATTR_W-1:0] walk_attr,
   input  logic              lock_en,
   input  logic [LOCK_W-1:0] lock_idx,
   input  logic              inv_all,
   input  logic              inv_asid_en,
   input  logic [ASID_W-1:0] inv_asid
);
   if (MAIN_LOCK < 1 || MAIN_LOCK >= MAIN_DEPTH) begin : g_bad_cfg
      $error("two_level_tlb: MAIN_LOCK out of range");
   end

   tlb_ent_t          iu_ent, du_ent, mn_ent, fill_ent;
   logic              iu_hit, du_hit, mn_hit;
   logic              i_miss, d_miss, gnt_d, gnt_i, refill, iu_wr, du_wr;
   logic              busy_q, side_q;
   logic [VA_W-1:0]   wva_q, mn_va;
   logic [ASID_W-1:0] wasid_q;

   assign i_miss = i_req && !iu_hit;
   assign d_miss = d_req && !du_hit;
   assign gnt_d  = !busy_q && d_miss;              // data side wins the main TLB
   assign gnt_i  = !busy_q && i_miss && !d_miss;
   assign mn_va  = gnt_d ? d_va : i_va;
   assign refill = busy_q && walk_valid;

   always_comb begin
      fill_ent = mn_ent;
      if (refill) begin
         fill_ent.vtag  = wva_q[VA_W-1:OFF_W];
         fill_ent.pbase = walk_pbase;
         fill_ent.size  = pg_size_e'(walk_size);
         fill_ent.asid  = wasid_q;
         fill_ent.glob  = walk_global;
         fill_ent.dom   = walk_domain;
         fill_ent.attr  = walk_attr;
      end
   end

   assign du_wr = (gnt_d && mn_hit) || (refill && side_q);
   assign iu_wr = (gnt_i && mn_hit) || (refill && !side_q);

   tlb_cam #(.DEPTH(MICRO_DEPTH), .NLOCK(0)) u_imicro (
      .clk(clk), .rst_n(rst_n), .lk_va(i_va), .lk_asid(cur_asid), .lk_hit(iu_hit), .lk_ent(iu_ent),
      .wr_en(iu_wr), .wr_ent(fill_ent), .wr_lock(1'b0), .wr_lock_idx(1'b0),
      .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid));

   tlb_cam #(.DEPTH(MICRO_DEPTH), .NLOCK(0)) u_dmicro (
      .clk(clk), .rst_n(rst_n), .lk_va(d_va), .lk_asid(cur_asid), .lk_hit(du_hit), .lk_ent(du_ent),
      .wr_en(du_wr), .wr_ent(fill_ent), .wr_lock(1'b0), .wr_lock_idx(1'b0),
      .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid));

   tlb_cam #(.DEPTH(MAIN_DEPTH), .NLOCK(MAIN_LOCK)) u_main (
      .clk(clk), .rst_n(rst_n), .lk_va(mn_va), .lk_asid(cur_asid), .lk_hit(mn_hit), .lk_ent(mn_ent),
      .wr_en(refill), .wr_ent(fill_ent), .wr_lock(lock_en), .wr_lock_idx(lock_idx),
      .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid));

   // walk tracking: one outstanding walk at a time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         side_q  <= 1'b0;
         wva_q   <= '0;
         wasid_q <= '0;
      end else if (refill) begin
         busy_q <= 1'b0;
      end else if ((gnt_d || gnt_i) && !mn_hit) begin
         busy_q  <= 1'b1;
         side_q  <= gnt_d;
         wva_q   <= mn_va;
         wasid_q <= cur_asid;
      end
   end

   assign walk_req  = busy_q;
   assign walk_side = side_q;
   assign walk_va   = wva_q;

   assign i_hit    = i_req && iu_hit;
   assign i_pa     = xlate(iu_ent, i_va);
   assign i_domain = iu_ent.dom;
   assign i_attr   = iu_ent.attr;
   assign d_hit    = d_req && du_hit;
   assign d_pa     = xlate(du_ent, d_va);
   assign d_domain = du_ent.dom;
   assign d_attr   = du_ent.attr;

   AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && !walk_valid) |=> (walk_req && $stable(walk_va) && $stable(walk_side))); // R6
   AST_D_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!walk_req && i_req && d_req && !i_hit && !d_hit) |=>
      (!i_hit || (i_va != $past(i_va)) || (cur_asid != $past(cur_asid)))); // R5
   AST_NO_WALK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!walk_req && d_req && d_hit && !i_req) |=> !walk_req); // R4
endmodule

// File: tb/two_level_tlb_tb.sv
`timescale 1ns/1ps
module two_level_tlb_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cur_asid = '0;
   logic        i_req = 1'b0, d_req = 1'b0;
   logic [31:0] i_va = '0, d_va = '0;
   logic        i_hit, d_hit, walk_req, walk_side;
   logic [31:0] i_pa, d_pa, walk_va;
   logic [3:0]  i_domain, i_attr, d_domain, d_attr;
   logic        walk_valid = 1'b0;
   logic [19:0] rsp_pbase = '0;
   logic [1:0]  rsp_size = '0;
   logic        rsp_glob = 1'b0;
   logic [3:0]  rsp_dom = '0, rsp_attr = '0;
   logic        rsp_lock = 1'b0;
   logic [1:0]  rsp_lidx = '0;
   logic        inv_all = 1'b0, inv_asid_en = 1'b0;
   logic [7:0]  inv_asid = '0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   two_level_tlb u_dut (
      .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid),
      .i_req(i_req), .i_va(i_va), .i_hit(i_hit), .i_pa(i_pa), .i_domain(i_domain), .i_attr(i_attr),
      .d_req(d_req), .d_va(d_va), .d_hit(d_hit), .d_pa(d_pa), .d_domain(d_domain), .d_attr(d_attr),
      .walk_req(walk_req), .walk_side(walk_side), .walk_va(walk_va), .walk_valid(walk_valid),
      .walk_pbase(rsp_pbase), .walk_size(rsp_size), .walk_global(rsp_glob),
      .walk_domain(rsp_dom), .walk_attr(rsp_attr), .lock_en(rsp_lock), .lock_idx(rsp_lidx),
      .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_rsp(input logic [19:0] pb, input logic [1:0] sz, input logic g,
                          input logic [3:0] dm, input logic [3:0] at);
      rsp_pbase = pb; rsp_size = sz; rsp_glob = g; rsp_dom = dm; rsp_attr = at;
   endtask

   // one request on one side; answers any walk for one cycle; returns cycles until hit
   task automatic access(input bit side, input logic [31:0] va, output int lat,
                         output logic [31:0] pa, output logic [3:0] dm, output logic [3:0] at);
      @(negedge clk);
      if (side) begin d_req = 1'b1; d_va = va; end
      else      begin i_req = 1'b1; i_va = va; end
      lat = 0;
      forever begin
         #1;
         if (side ? d_hit : i_hit) break;
         if (walk_req) begin
            chk(walk_va == va && walk_side == side, "R6 walk address/side", {walk_side, walk_va}, {side, va});
            walk_valid = 1'b1;
         end
         @(negedge clk);
         walk_valid = 1'b0;
         lat++;
         if (lat > 40) break;
      end
      pa = side ? d_pa : i_pa;
      dm = side ? d_domain : i_domain;
      at = side ? d_attr : i_attr;
      d_req = 1'b0; i_req = 1'b0;
   endtask

   task automatic probe(input bit side, input logic [31:0] va, input int exp_lat,
                        input logic [31:0] exp_pa, input string tag);
      int lat; logic [31:0] pa; logic [3:0] dm, at;
      access(side, va, lat, pa, dm, at);
      chk(lat == exp_lat, {tag, " latency"}, 64'(lat), 64'(exp_lat));
      chk(pa == exp_pa, {tag, " address"}, pa, exp_pa);
   endtask

   task automatic pulse_inv_all();
      @(negedge clk); inv_all = 1'b1;
      @(negedge clk); inv_all = 1'b0;
   endtask

   task automatic test_reset();
      #1;
      chk(!i_hit && !d_hit, "R12 hits after reset", {i_hit, d_hit}, 0);
      chk(!walk_req, "R12 walk_req after reset", walk_req, 0);
   endtask

   task automatic test_basic();
      int lat; logic [31:0] pa; logic [3:0] dm, at;
      cur_asid = 8'd1;
      set_rsp(20'h12345, 2'd0, 1'b0, 4'd7, 4'hA);
      access(1'b1, 32'h0000_1ABC, lat, pa, dm, at);
      chk(lat == 2, "R6 walk refill latency", lat, 2);
      chk(pa == 32'h1234_5ABC, "R1 translated address", pa, 32'h1234_5ABC);
      chk(dm == 4'd7 && at == 4'hA, "R11 domain/attr", {dm, at}, 8'h7A);
      probe(1'b1, 32'h0000_1004, 0, 32'h1234_5004, "R1 micro hit");
      probe(1'b0, 32'h0000_1FF0, 1, 32'h1234_5FF0, "R4 main hit to instruction micro");
   endtask

   task automatic test_sizes();
      set_rsp(20'h9A000, 2'd3, 1'b0, 4'd1, 4'h1);
      probe(1'b1, 32'h4512_3456, 2, 32'h9A12_3456, "R2 16MB fill");
      probe(1'b1, 32'h45FF_0010, 0, 32'h9AFF_0010, "R2 16MB other offset");
      set_rsp(20'h70000, 2'd1, 1'b0, 4'd2, 4'h2);
      probe(1'b1, 32'h1234_5678, 2, 32'h7000_5678, "R2 64KB fill");
      probe(1'b1, 32'h1234_F000, 0, 32'h7000_F000, "R2 64KB other offset");
      set_rsp(20'h55555, 2'd0, 1'b0, 4'd3, 4'h3);
      probe(1'b1, 32'h1235_0000, 2, 32'h5555_5000, "R2 outside 64KB page");
      set_rsp(20'h30000, 2'd2, 1'b0, 4'd4, 4'h4);
      probe(1'b1, 32'h2010_0ABC, 2, 32'h3000_0ABC, "R2 1MB fill");
      probe(1'b1, 32'h201F_FFFF, 0, 32'h300F_FFFF, "R2 1MB other offset");
   endtask

   task automatic test_prio();
      int ti, td;
      set_rsp(20'hA0000, 2'd0, 1'b0, 4'd5, 4'h5);
      probe(1'b0, 32'h0300_0000, 2, 32'hA000_0000, "R5 setup instruction page");
      set_rsp(20'hB0000, 2'd0, 1'b0, 4'd6, 4'h6);
      probe(1'b1, 32'h0301_0000, 2, 32'hB000_0000, "R5 setup data page");
      ti = -1; td = -1;
      @(negedge clk);
      i_req = 1'b1; i_va = 32'h0301_0000;
      d_req = 1'b1; d_va = 32'h0300_0000;
      for (int k = 0; k < 6; k++) begin
         #1;
         if (d_hit && td < 0) td = k;
         if (i_hit && ti < 0) ti = k;
         @(negedge clk);
      end
      i_req = 1'b0; d_req = 1'b0;
      chk(td == 1, "R5 data side first", td, 1);
      chk(ti == 2, "R5 instruction side one cycle later", ti, 2);
   endtask

   task automatic test_asid();
      cur_asid = 8'd5;
      set_rsp(20'h40000, 2'd0, 1'b0, 4'd0, 4'h0);
      probe(1'b1, 32'h0400_0000, 2, 32'h4000_0000, "R3 private page asid5");
      set_rsp(20'h41000, 2'd0, 1'b1, 4'd0, 4'h0);
      probe(1'b1, 32'h0410_0000, 2, 32'h4100_0000, "R3 global page");
      cur_asid = 8'd6;
      set_rsp(20'h46000, 2'd0, 1'b0, 4'd0, 4'h0);
      probe(1'b1, 32'h0400_0000, 2, 32'h4600_0000, "R3 other asid misses");
      probe(1'b1, 32'h0410_0000, 0, 32'h4100_0000, "R3 global hits any asid");
      cur_asid = 8'd5;
      probe(1'b1, 32'h0400_0000, 0, 32'h4000_0000, "R3 asid5 back without flush");
      @(negedge clk); inv_asid_en = 1'b1; inv_asid = 8'd5;
      @(negedge clk); inv_asid_en = 1'b0;
      cur_asid = 8'd6;
      probe(1'b1, 32'h0400_0000, 0, 32'h4600_0000, "R10 other asid kept");
      probe(1'b1, 32'h0410_0000, 0, 32'h4100_0000, "R10 global kept");
      cur_asid = 8'd5;
      set_rsp(20'h40000, 2'd0, 1'b0, 4'd0, 4'h0);
      probe(1'b1, 32'h0400_0000, 2, 32'h4000_0000, "R10 asid5 removed from both levels");
   endtask

   task automatic test_micro_rr();
      pulse_inv_all();
      cur_asid = 8'd1;
      for (int k = 0; k < 9; k++) begin
         set_rsp(20'h50000 + 20'(k), 2'd0, 1'b0, 4'd0, 4'h0);
         probe(1'b1, 32'h0500_0000 + (k << 12), 2, {20'h50000 + 20'(k), 12'h0}, "R7 fill");
      end
      probe(1'b1, 32'h0500_0000, 1, 32'h5000_0000, "R7 evicted from micro, kept in main");
      probe(1'b1, 32'h0500_8000, 0, 32'h5000_8000, "R7 newest still in micro");
   endtask

   task automatic test_lock();
      pulse_inv_all();
      rsp_lock = 1'b1; rsp_lidx = 2'd2;
      set_rsp(20'h60000, 2'd0, 1'b0, 4'd9, 4'h9);
      probe(1'b1, 32'h0600_0000, 2, 32'h6000_0000, "R8 locked refill");
      rsp_lock = 1'b0;
      for (int k = 0; k < 30; k++) begin
         set_rsp(20'h70000 + 20'(k), 2'd0, 1'b0, 4'd0, 4'h0);
         probe(1'b1, 32'h0700_0000 + (k << 12), 2, {20'h70000 + 20'(k), 12'h0}, "R8 fill");
      end
      probe(1'b1, 32'h0600_0000, 1, 32'h6000_0000, "R8 locked not evicted");
      set_rsp(20'h70000, 2'd0, 1'b0, 4'd0, 4'h0);
      probe(1'b1, 32'h0700_0000, 2, 32'h7000_0000, "R8 oldest unlocked evicted");
      probe(1'b1, 32'h0700_5000, 1, 32'h7000_5000, "R8 recent unlocked kept");
      pulse_inv_all();
      probe(1'b1, 32'h0600_0000, 1, 32'h6000_0000, "R9 locked survives invalidate-all");
      set_rsp(20'h7001D, 2'd0, 1'b0, 4'd0, 4'h0);
      probe(1'b1, 32'h0701_D000, 2, 32'h7001_D000, "R9 unlocked cleared");
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_basic();
      test_sizes();
      test_prio();
      test_asid();
      test_micro_rr();
      test_lock();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule